// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets logic running on a synchronous clock read and write one word at a time in an external asynchronous static RAM. The RAM has a pair of chip selects with opposite polarity, an active-low output enable, an active-low write enable and a shared data bus. At the pad level that bus is split here into an input, an output and an output-enable.

The internal side is a simple valid/ready request port with a write flag, an address and write data. The controller accepts one request whenever it is idle and replays it on the RAM pins as a fixed sequence of clock cycles. It then answers with a one-cycle acknowledge that carries read data for reads.

Phase lengths are parameters derived from the RAM's minimum and maximum delays at the chosen clock. The defaults fit a 10 ns clock:

- A read holds the pins for five cycles.
- A write holds write enable low for four cycles inside a five-cycle window.

When a write follows a read, the controller inserts a high-impedance gap before it drives the bus.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and after it is released, the pins are idle: ram_ce1_n=1, ram_ce2=0, ram_oe_n=1, ram_we_n=1, ram_dq_oe=0. Also ack=0 and req_ready=1.
- R2: The RAM counts as selected only when ram_ce1_n=0 and ram_ce2=1. The two select pins always change together (ram_ce1_n equals the inverse of ram_ce2 in every cycle). ram_oe_n or ram_we_n is low only while the RAM is selected.
- R3: A read drives exactly RD_CYC consecutive cycles with the RAM selected and ram_oe_n=0. Across those cycles ram_we_n=1, ram_dq_oe=0 and ram_addr stays constant at the accepted address.
- R4: rdata equals the value on ram_dq_i in the last cycle of the read phase. ack is high for exactly one cycle, RD_CYC+1 cycles after the accepting clock edge.
- R5: A write window lasts WR_CYC cycles with the RAM selected, ram_oe_n=1 and ram_dq_oe=1 throughout. ram_we_n is low for its first WE_CYC consecutive cycles (WE_CYC < WR_CYC).
- R6: ram_we_n rises while the RAM is still selected, so write enable always ends the write. In the cycle after it rises, ram_addr and ram_dq_o are unchanged. The select pins never return to idle in the same cycle that ram_we_n rises.
- R7: ram_dq_oe is high only when ram_oe_n is high in that cycle and was high in each of the previous TURN_CYC cycles.
- R8: A write acknowledges WR_CYC+1+g cycles after the accepting edge. The gap g is max(0, TURN_CYC-k). Here k is the number of cycles from the ack cycle of the latest read up to and including the cycle in which the write was accepted. With the defaults:
  - a write taken in a read's ack cycle waits one cycle;
  - a write taken one cycle later waits none;
  - consecutive writes wait none.
- R9: req_ready is high only while the controller is idle, including the ack cycle. A request is taken on a clock edge where req_valid and req_ready are both high, and req_ready is low in the next cycle. A request held while the block is busy is kept, not refused, and is taken at the first ready cycle.
- R10: During a write window, ram_addr and ram_dq_o carry the accepted address and data. A later read of that address returns that data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (17) | Word address |
| req_wdata | input | DATA_W (8) | Write data |
| req_ready | output | 1 | Controller idle, request will be taken |
| ack | output | 1 | One-cycle completion strobe |
| rdata | output | DATA_W (8) | Read data, valid while ack is high after a read |
| ram_addr | output | ADDR_W (17) | RAM address pins |
| ram_dq_o | output | DATA_W (8) | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Pad output enable for ram_dq_o |
| ram_dq_i | input | DATA_W (8) | Data received from the RAM |
| ram_ce1_n | output | 1 | Active-low chip select |
| ram_ce2 | output | 1 | Active-high chip select |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_we_n | output | 1 | Active-low write enable |

## Verification
The bench uses the default parameters: RD_CYC=5, WE_CYC=4, WR_CYC=5, TURN_CYC=2, a 17-bit address and 8-bit data. With a gap requirement of two cycles, a write taken in a read's ack cycle needs exactly one filler cycle, and a write taken one idle cycle later needs none, so both sides of the R8 boundary are exercised. The bench's RAM model presents valid data only in the fifth selected read cycle, which exposes any sampling taken earlier. The address range reaches both the all-zero and the all-ones address.

// File: rtl/sram_pkg.sv
package sram_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_GAP   = 2'd2,
        PH_WRITE = 2'd3
    } phase_e;

    // active-high view of the RAM strobes, converted to pin polarity at the pads
    typedef struct packed {
        logic sel;
        logic rd_en;
        logic wr_en;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{sel: 1'b0, rd_en: 1'b0, wr_en: 1'b0, drive: 1'b0};

    function automatic strobe_t phase_strobes(phase_e ph, logic we_window);
        strobe_t s;
        s = STROBE_IDLE;
        case (ph)
            PH_READ: begin
                s.sel   = 1'b1;
                s.rd_en = 1'b1;
            end
            PH_WRITE: begin
                s.sel   = 1'b1;
                s.wr_en = we_window;
                s.drive = 1'b1;
            end
            default: s = STROBE_IDLE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sram_turn.sv
module sram_turn #(
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic oe_n_pin,
    output logic gap_ok
);
    localparam int HI_W = $clog2(TURN_CYC + 2);
    localparam logic [HI_W-1:0] HI_MAX = HI_W'(TURN_CYC);

    // consecutive completed cycles with output enable high
    logic [HI_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= HI_MAX;
        end else if (!oe_n_pin) begin
            hi_q <= '0;
        end else if (hi_q != HI_MAX) begin
            hi_q <= hi_q + HI_W'(1);
        end
    end

    // the current cycle also has output enable high when the bus is free,
    // so it counts toward the gap ahead of the first driven cycle
    assign gap_ok = oe_n_pin && ((hi_q + HI_W'(1)) >= HI_MAX);

    assert_hi_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !oe_n_pin |=> (hi_q == '0));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8,
    parameter int RD_CYC = 5,
    parameter int WE_CYC = 4,
    parameter int WR_CYC = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              gap_ok,
    input  logic [DATA_W-1:0] dq_in,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_wdata,
    output strobe_t           strobe_d
);
    localparam int MAX_CYC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_CYC - 1);
    localparam logic [CNT_W-1:0] WE_LEN  = CNT_W'(WE_CYC);

    phase_e           ph_q, ph_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             take;
    logic             rd_last, wr_last;

    assign rd_last   = (ph_q == PH_READ)  && (cnt_q == RD_LAST);
    assign wr_last   = (ph_q == PH_WRITE) && (cnt_q == WR_LAST);
    assign req_ready = (ph_q == PH_IDLE);

    always_comb begin
        ph_d  = ph_q;
        cnt_d = cnt_q;
        take  = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req_valid) begin
                    take  = 1'b1;
                    cnt_d = '0;
                    if (!req_write) begin
                        ph_d = PH_READ;
                    end else if (gap_ok) begin
                        ph_d = PH_WRITE;
                    end else begin
                        ph_d = PH_GAP;
                    end
                end
            end
            PH_READ: begin
                if (rd_last) ph_d = PH_IDLE;
                else         cnt_d = cnt_q + CNT_W'(1);
            end
            PH_GAP: begin
                if (gap_ok) begin
                    ph_d  = PH_WRITE;
                    cnt_d = '0;
                end
            end
            PH_WRITE: begin
                if (wr_last) ph_d = PH_IDLE;
                else         cnt_d = cnt_q + CNT_W'(1);
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    // pin strobes for the coming cycle; registered by the pad stage
    assign strobe_d = phase_strobes(ph_d, cnt_d < WE_LEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            cnt_q    <= '0;
            ack      <= 1'b0;
            rdata    <= '0;
            op_addr  <= '0;
            op_wdata <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            ack   <= rd_last || wr_last;
            if (rd_last) rdata <= dq_in;
            if (take) begin
                op_addr  <= req_addr;
                op_wdata <= req_wdata;
            end
        end
    end

    assert_ack_single_R4: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    assert_take_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    assert_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (ph_q != PH_IDLE) |=> $stable(op_addr));

endmodule

// File: rtl/sram_pads.sv
module sram_pads
    import sram_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strobe_d,
    output logic    ce1_n,
    output logic    ce2,
    output logic    oe_n,
    output logic    we_n,
    output logic    dq_oe
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ce1_n <= 1'b1;
            ce2   <= 1'b0;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce1_n <= !strobe_d.sel;
            ce2   <= strobe_d.sel;
            oe_n  <= !strobe_d.rd_en;
            we_n  <= !strobe_d.wr_en;
            dq_oe <= strobe_d.drive;
        end
    end

    assert_oe_needs_sel_R2: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!ce1_n && ce2));
    assert_we_quiet_bus_R5: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce1_n && ce2 && oe_n && dq_oe));
    assert_we_ends_write_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (!ce1_n && ce2));
    assert_desel_after_we_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ce1_n) |-> $past(we_n));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sram_pkg::*;
#(
    parameter int ADDR_W   = 17,
    parameter int DATA_W   = 8,
    parameter int RD_CYC   = 5,
    parameter int WE_CYC   = 4,
    parameter int WR_CYC   = 5,
    parameter int TURN_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_dq_o,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_i,
    output logic              ram_ce1_n,
    output logic              ram_ce2,
    output logic              ram_oe_n,
    output logic              ram_we_n
);
    strobe_t strobe_d;
    logic    gap_ok;

    sram_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RD_CYC (RD_CYC),
        .WE_CYC (WE_CYC),
        .WR_CYC (WR_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .gap_ok    (gap_ok),
        .dq_in     (ram_dq_i),
        .req_ready (req_ready),
        .ack       (ack),
        .rdata     (rdata),
        .op_addr   (ram_addr),
        .op_wdata  (ram_dq_o),
        .strobe_d  (strobe_d)
    );

    sram_pads u_pads (
        .clk      (clk),
        .rst      (rst),
        .strobe_d (strobe_d),
        .ce1_n    (ram_ce1_n),
        .ce2      (ram_ce2),
        .oe_n     (ram_oe_n),
        .we_n     (ram_we_n),
        .dq_oe    (ram_dq_oe)
    );

    sram_turn #(
        .TURN_CYC (TURN_CYC)
    ) u_turn (
        .clk      (clk),
        .rst      (rst),
        .oe_n_pin (ram_oe_n),
        .gap_ok   (gap_ok)
    );

    // pin-level watch of the bus turnaround, counted independently of u_turn
    localparam int RUN_W = $clog2(TURN_CYC + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(TURN_CYC);
    logic [RUN_W-1:0] oe_hi_run;

    always_ff @(posedge clk) begin
        if (rst)                   oe_hi_run <= RUN_MAX;
        else if (!ram_oe_n)        oe_hi_run <= '0;
        else if (oe_hi_run != RUN_MAX) oe_hi_run <= oe_hi_run + RUN_W'(1);
    end

    assert_no_contention_R7: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> (ram_oe_n && (oe_hi_run >= RUN_MAX)));
    assert_sel_pair_R2: assert property (@(posedge clk) disable iff (rst)
        ram_ce1_n == !ram_ce2);
    assert_read_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (!ram_oe_n && $past(!ram_oe_n)) |-> $stable(ram_addr));
    assert_read_no_drive_R3: assert property (@(posedge clk) disable iff (rst)
        !ram_oe_n |-> (ram_we_n && !ram_dq_oe));

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int CLK_NS = 10;
    localparam int AW = 17;
    localparam int DW = 8;
    localparam int RD_CYC = 5;
    localparam int WE_CYC = 4;
    localparam int WR_CYC = 5;
    localparam int TURN_CYC = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, ack;
    logic [DW-1:0] rdata;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_dq_o;
    logic          ram_dq_oe;
    logic [DW-1:0] ram_dq_i = '0;
    logic          ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n;

    sram_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD_CYC),
        .WE_CYC(WE_CYC), .WR_CYC(WR_CYC), .TURN_CYC(TURN_CYC)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .ack(ack), .rdata(rdata), .ram_addr(ram_addr), .ram_dq_o(ram_dq_o),
        .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i), .ram_ce1_n(ram_ce1_n),
        .ram_ce2(ram_ce2), .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n)
    );

    always #(CLK_NS / 2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // RAM contents seen by the model, and the bench's own expectation
    logic [DW-1:0] mem [int];
    logic [DW-1:0] shadow [int];

    function automatic logic [DW-1:0] init_val(logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [DW-1:0] mem_rd(logic [AW-1:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return init_val(a);
    endfunction

    typedef struct {
        bit            wr;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        int            due;
    } item_t;
    item_t sb[$];

    int last_rd_ack = -100;

    task automatic op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        item_t it;
        int c, k, g;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        c = cyc;
        it.wr = wr;
        it.a  = a;
        if (wr) begin
            k = c - last_rd_ack + 1;
            g = (k < TURN_CYC) ? TURN_CYC - k : 0;
            it.d   = d;
            it.due = c + WR_CYC + 1 + g;
            shadow[int'(a)] = d;
        end else begin
            it.d   = shadow.exists(int'(a)) ? shadow[int'(a)] : init_val(a);
            it.due = c + RD_CYC + 1;
            last_rd_ack = it.due;
        end
        sb.push_back(it);
        @(negedge clk);
        chk(!req_ready, "R9 ready after take", int'(req_ready), 0);
        req_valid = 1'b0;
    endtask

    task automatic idle_after_ack(input int n);
        while (!req_ready) @(negedge clk);
        repeat (n) @(negedge clk);
    endtask

    // RAM model and pin monitor
    int            oe_hi = TURN_CYC;
    int            rd_age = 0;
    int            wlo = 0;
    logic [AW-1:0] rd_addr = '0;
    logic [AW-1:0] wa = '0;
    logic [DW-1:0] wd = '0;
    bit            prev_sel = 1'b0;
    bit            prev_we_n = 1'b1;

    always @(negedge clk) begin
        bit sel, reading;
        item_t it;
        if (!rst) begin
            chk(ram_ce1_n == !ram_ce2, "R2 select pair", int'(ram_ce1_n), int'(!ram_ce2));
            sel = !ram_ce1_n && ram_ce2;
            if (!ram_oe_n || !ram_we_n) chk(sel, "R2 strobe without select", int'(sel), 1);
            if (ram_dq_oe) chk(ram_oe_n && oe_hi >= TURN_CYC, "R7 bus turnaround", oe_hi, TURN_CYC);
            oe_hi = ram_oe_n ? ((oe_hi < TURN_CYC) ? oe_hi + 1 : oe_hi) : 0;

            reading = sel && !ram_oe_n;
            if (reading) begin
                chk(ram_we_n && !ram_dq_oe, "R3 read strobes", int'({ram_we_n, ram_dq_oe}), 2);
                if (rd_age > 0) chk(ram_addr == rd_addr, "R3 read address", int'(ram_addr), int'(rd_addr));
                rd_addr = ram_addr;
                rd_age++;
            end else if (rd_age > 0) begin
                chk(rd_age == RD_CYC, "R3 read length", rd_age, RD_CYC);
                rd_age = 0;
            end
            ram_dq_i = (reading && rd_age >= RD_CYC) ? mem_rd(ram_addr) : ~mem_rd(ram_addr);

            if (sel && !ram_we_n) begin
                chk(ram_oe_n && ram_dq_oe, "R5 write strobes", int'({ram_oe_n, ram_dq_oe}), 3);
                wa = ram_addr;
                wd = ram_dq_o;
                wlo++;
            end else if (wlo > 0) begin
                chk(wlo == WE_CYC, "R5 write pulse length", wlo, WE_CYC);
                chk(sel && ram_dq_oe, "R6 select held after write", int'({sel, ram_dq_oe}), 3);
                chk(ram_addr == wa && ram_dq_o == wd, "R6 addr and data hold", int'(ram_dq_o), int'(wd));
                if (sb.size() > 0)
                    chk(sb[0].wr && wa == sb[0].a && wd == sb[0].d, "R10 written word",
                        int'(wd), int'(sb[0].d));
                mem[int'(wa)] = wd;
                wlo = 0;
            end
            if (prev_sel && !sel) chk(prev_we_n, "R6 deselect order", int'(prev_we_n), 1);
            prev_sel  = sel;
            prev_we_n = ram_we_n;

            if (ack) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R4 unexpected ack", 1, 0);
                end else begin
                    it = sb.pop_front();
                    chk(cyc == it.due, it.wr ? "R8 write latency" : "R4 read latency", cyc, it.due);
                    if (!it.wr) chk(rdata == it.d, "R4 read data", int'(rdata), int'(it.d));
                end
            end else if (sb.size() > 0 && cyc > sb[0].due) begin
                it = sb.pop_front();
                chk(1'b0, "R4 missing ack", cyc, it.due);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ram_ce1_n && !ram_ce2 && ram_oe_n && ram_we_n && !ram_dq_oe, "R1 pins in reset",
            int'({ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe}), 'h16);
        chk(!ack && req_ready, "R1 port in reset", int'({ack, req_ready}), 1);
        rst = 1'b0;
        @(negedge clk);
        chk(ram_ce1_n && !ram_ce2 && ram_oe_n && ram_we_n && !ram_dq_oe, "R1 pins after reset",
            int'({ram_ce1_n, ram_ce2, ram_oe_n, ram_we_n, ram_dq_oe}), 'h16);

        // consecutive writes at both address extremes: no gap (R8)
        op(1'b1, '0, 8'h00);
        op(1'b1, '1, 8'hFF);
        // read right after a write, then a write taken in the read's ack cycle (R8 gap of one)
        op(1'b0, '1, 8'h00);
        op(1'b1, 17'h00123, 8'hA5);
        // read, then a write after one idle cycle (R8 no gap)
        op(1'b0, '0, 8'h00);
        idle_after_ack(1);
        op(1'b1, 17'h00124, 8'h3C);
        // read back written and never-written words (R10)
        op(1'b0, 17'h00123, 8'h00);
        op(1'b0, 17'h00124, 8'h00);
        op(1'b0, 17'h1ABCD, 8'h00);
        idle_after_ack(3);
        // mixed traffic with varying spacing
        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a;
            a = AW'(17'h00040 + (i % 6) * 17'h0100B);
            op(i % 3 != 2, a, 8'(i * 37 + 11));
            if (i % 4 == 3) idle_after_ack(i % 3);
        end
        for (int i = 0; i < 6; i++) op(1'b0, AW'(17'h00040 + i * 17'h0100B), 8'h00);

        while (sb.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule